// File: doc/BRIEF.md
# Gated-Window Frequency Counter

This block measures the frequency of an external square wave. The wave is not synchronised to the system clock. A request starts a measurement. The block then waits for the next boundary of a fixed gate period and counts the rising edges of the input until the boundary after that. With a one-second gate the count is the frequency in hertz, and no division is needed.

When the gate closes, the block latches the count. It also produces a two-digit kilohertz reading as two seven-segment patterns, and raises a done flag. The reading stays frozen until a clear request sends the block through a clearing step back to idle.

Everything runs on one edge of one clock. The measured input goes through a synchroniser and an edge detector. The gate boundaries come from a prescaled tick with a parameterised ratio. The kilohertz digits are built while the counting runs: a modulo-SCALE sub-counter steps a saturating decimal pair, so the digits are ready in the same cycle the gate closes.

Top module: `gated_freq_counter`

## Requirements
- R1: After synchronous reset, done is 0, freq_hz is 0 and both digit outputs show the pattern for 0 (7'h3F).
- R2: A start request is accepted only while the block is idle. A start request while a measurement runs or a result is held has no effect on the timing or the value of the result. Without a start request the block stays idle and done stays 0.
- R3: Counting opens at the first gate tick after the start request and closes at the next tick. Done rises between TICK_DIV and 2*TICK_DIV+4 cycles after the start request is sampled.
- R4: freq_hz equals the number of input rising edges inside one gate window. For an input with period P cycles, where P divides TICK_DIV, this is TICK_DIV/P. A constant input gives 0.
- R5: The reading is floor(freq_hz/SCALE), shown as a tens digit and a units digit. If the reading exceeds 99, both digits show 99.
- R6: Each digit output is active high with bit 0 = segment a through bit 6 = segment g. The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R7: While done is high, done, freq_hz and both digits hold their values. A clear request drops done on the next cycle, and two cycles later freq_hz is 0 and the digits show 0. A clear request during a measurement is ignored.
- R8: freq_hz and both digit outputs are valid in the same cycle that done rises.
- R9: An input pulse that is high for a single system clock cycle is counted exactly once. The internal edge pulse never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start a measurement (taken only when idle) |
| clear_req | input | 1 | Release a held result and return to idle |
| sig_in | input | 1 | Asynchronous square wave under measurement |
| done | output | 1 | Result valid and held |
| freq_hz | output | CW | Edge count of the last window |
| seg_tens | output | 7 | Tens digit of the kHz reading, segments g..a |
| seg_units | output | 7 | Units digit of the kHz reading, segments g..a |

## Verification
The input is a pulse train whose period divides the gate length, so every window holds an exact, phase-independent edge count. A one-cycle-high train at period 2 tests the edge detector at its fastest rate. Longer periods drawn at random with a fixed seed give readings across both digits. A flat input tells a dead counter from a stuck one. A second instance with a small SCALE drives the reading to exactly 100 and above, which separates correct saturation at 99 from wrap-around and from a tens digit that runs past 9. Start and clear pulses placed in the middle of a measurement, plus long waits in the hold and idle states, show whether those requests leak into states where they must have no effect.

// File: rtl/fm_pkg.sv
package fm_pkg;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_IDLE  = 2'd1,
    ST_MEAS  = 2'd2,
    ST_HOLD  = 2'd3
  } fm_state_t;

  // segments active high, bit0 = a ... bit6 = g
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0: seg_of = 7'h3F;
      4'd1: seg_of = 7'h06;
      4'd2: seg_of = 7'h5B;
      4'd3: seg_of = 7'h4F;
      4'd4: seg_of = 7'h66;
      4'd5: seg_of = 7'h6D;
      4'd6: seg_of = 7'h7D;
      4'd7: seg_of = 7'h07;
      4'd8: seg_of = 7'h7F;
      4'd9: seg_of = 7'h6F;
      default: seg_of = 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/fm_sync_edge.sv
module fm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      rise   <= 1'b0;
    end else begin
      last_q <= chain[STAGES-1];
      rise   <= chain[STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/fm_gate_tick.sv
module fm_gate_tick #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/fm_khz_acc.sv
module fm_khz_acc #(
  parameter int CW    = 17,
  parameter int SCALE = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] hz_nx,
  output logic [3:0]    tens_nx,
  output logic [3:0]    units_nx
);
  localparam int SW = $clog2(SCALE);
  localparam logic [SW-1:0] SUB_LAST = SW'(SCALE - 1);

  logic [CW-1:0] hz_q;
  logic [SW-1:0] sub_q, sub_nx;
  logic [3:0]    tens_q, units_q;

  always_comb begin
    hz_nx    = hz_q;
    sub_nx   = sub_q;
    tens_nx  = tens_q;
    units_nx = units_q;
    if (inc) begin
      hz_nx = hz_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        sub_nx = '0;
        if (tens_q == 4'd9 && units_q == 4'd9) begin
          tens_nx  = tens_q;
          units_nx = units_q;
        end else if (units_q == 4'd9) begin
          units_nx = 4'd0;
          tens_nx  = tens_q + 4'd1;
        end else begin
          units_nx = units_q + 4'd1;
        end
      end else begin
        sub_nx = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hz_q    <= '0;
      sub_q   <= '0;
      tens_q  <= '0;
      units_q <= '0;
    end else begin
      hz_q    <= hz_nx;
      sub_q   <= sub_nx;
      tens_q  <= tens_nx;
      units_q <= units_nx;
    end
  end
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fm_pkg::*;
#(
  parameter int TICK_DIV    = 50_000_000,
  parameter int SCALE       = 1000,
  parameter int CW          = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          clear_req,
  input  logic          sig_in,
  output logic          done,
  output logic [CW-1:0] freq_hz,
  output logic [6:0]    seg_tens,
  output logic [6:0]    seg_units
);
  fm_state_t     state;
  logic          gate_open;
  logic          gate_tick;
  logic          edge_pulse;
  logic          acc_clr, acc_inc;
  logic [CW-1:0] hz_nx;
  logic [3:0]    tens_nx, units_nx;

  fm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sig_in), .rise(edge_pulse)
  );

  fm_gate_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(gate_tick)
  );

  assign acc_clr = (state != ST_MEAS) || !gate_open;
  assign acc_inc = edge_pulse && (state == ST_MEAS) && gate_open;

  fm_khz_acc #(.CW(CW), .SCALE(SCALE)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .inc(acc_inc),
    .hz_nx(hz_nx), .tens_nx(tens_nx), .units_nx(units_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      gate_open <= 1'b0;
      done      <= 1'b0;
      freq_hz   <= '0;
      seg_tens  <= seg_of(4'd0);
      seg_units <= seg_of(4'd0);
    end else begin
      case (state)
        ST_CLEAR: begin
          done      <= 1'b0;
          gate_open <= 1'b0;
          freq_hz   <= '0;
          seg_tens  <= seg_of(4'd0);
          seg_units <= seg_of(4'd0);
          state     <= ST_IDLE;
        end
        ST_IDLE: begin
          gate_open <= 1'b0;
          if (start_req) state <= ST_MEAS;
        end
        ST_MEAS: begin
          if (gate_tick) begin
            if (!gate_open) begin
              gate_open <= 1'b1;
            end else begin
              gate_open <= 1'b0;
              freq_hz   <= hz_nx;
              seg_tens  <= seg_of(tens_nx);
              seg_units <= seg_of(units_nx);
              done      <= 1'b1;
              state     <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (clear_req) begin
            done  <= 1'b0;
            state <= ST_CLEAR;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker
  import fm_pkg::*;
#(
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start_req,
  input logic          clear_req,
  input logic          done,
  input logic [CW-1:0] freq_hz,
  input logic [6:0]    seg_tens,
  input logic [6:0]    seg_units,
  input fm_state_t     state,
  input logic          gate_open,
  input logic          tick,
  input logic          edge_p
);
  function automatic logic seg_ok(input logic [6:0] s);
    seg_ok = 1'b0;
    for (int d = 0; d < 10; d++)
      if (s == seg_of(4'(d))) seg_ok = 1'b1;
  endfunction

  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_req) |=> (state == ST_IDLE));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_req) |=> (state == ST_MEAS && !gate_open));

  assert_close_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(tick) && $past(gate_open)));

  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_seg_valid_R6: assert property (@(posedge clk) disable iff (rst)
    seg_ok(seg_tens) && seg_ok(seg_units));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !clear_req) |=> (done && $stable(freq_hz) && $stable(seg_tens) && $stable(seg_units)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (done && clear_req) |=> !done);

  assert_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
    edge_p |=> !edge_p);
endmodule

bind gated_freq_counter fm_checker #(.CW(CW)) u_fm_checker (
  .clk(clk), .rst(rst), .start_req(start_req), .clear_req(clear_req),
  .done(done), .freq_hz(freq_hz), .seg_tens(seg_tens), .seg_units(seg_units),
  .state(state), .gate_open(gate_open), .tick(gate_tick), .edge_p(edge_pulse)
);

// File: tb/gated_freq_counter_bench.sv
module gated_freq_counter_bench;
  localparam int W   = 3000;
  localparam int SCA = 100;
  localparam int SCB = 10;
  localparam int CW  = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic clear_req = 1'b0;
  logic sig_in = 1'b0;
  logic done_a, done_b;
  logic [CW-1:0] hz_a, hz_b;
  logic [6:0] st_a, su_a, st_b, su_b;

  int per_cfg = 10;
  bit gen_en = 1'b1;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gated_freq_counter #(.TICK_DIV(W), .SCALE(SCA), .CW(CW)) u_gated_freq_counter (
    .clk(clk), .rst(rst), .start_req(start_req), .clear_req(clear_req), .sig_in(sig_in),
    .done(done_a), .freq_hz(hz_a), .seg_tens(st_a), .seg_units(su_a));

  gated_freq_counter #(.TICK_DIV(W), .SCALE(SCB), .CW(CW)) u_gated_freq_counter_sat (
    .clk(clk), .rst(rst), .start_req(start_req), .clear_req(clear_req), .sig_in(sig_in),
    .done(done_b), .freq_hz(hz_b), .seg_tens(st_b), .seg_units(su_b));

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F; 4: pat = 7'h66;
      5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07; 8: pat = 7'h7F; default: pat = 7'h6F;
    endcase
  endfunction

  function automatic int exp_hz(input int p, input bit en);
    return en ? (W / p) : 0;
  endfunction

  function automatic int exp_khz(input int hz, input int sc);
    int k;
    k = hz / sc;
    return (k > 99) ? 99 : k;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // pulse train: high one cycle per period
  initial begin
    forever begin
      int p;
      p = per_cfg;
      for (int k = 0; k < p; k++) begin
        @(negedge clk);
        sig_in = gen_en && (k == 0);
      end
    end
  end

  task automatic check_result(input int p, input bit en);
    int hz, ka, kb;
    hz = exp_hz(p, en);
    ka = exp_khz(hz, SCA);
    kb = exp_khz(hz, SCB);
    check(int'(hz_a) == hz, "R4 count A", int'(hz_a), hz);
    check(int'(hz_b) == hz, "R4 count B", int'(hz_b), hz);
    check(st_a == pat(ka / 10) && su_a == pat(ka % 10), "R5/R6/R8 digits A",
          int'({st_a, su_a}), int'({pat(ka / 10), pat(ka % 10)}));
    check(st_b == pat(kb / 10) && su_b == pat(kb % 10), "R5/R6/R8 digits B saturation",
          int'({st_b, su_b}), int'({pat(kb / 10), pat(kb % 10)}));
  endtask

  task automatic do_clear();
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    check(!done_a && !done_b, "R7 done drops after clear", int'(done_a), 0);
    @(negedge clk);
    @(negedge clk);
    check(hz_a == '0 && st_a == 7'h3F && su_a == 7'h3F, "R7 cleared outputs", int'(hz_a), 0);
  endtask

  task automatic run_meas(input int p, input bit en, input bit clear_after);
    int n;
    per_cfg = p;
    gen_en = en;
    repeat (700 + $urandom_range(0, 200)) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    n = 1;
    while (!done_a && n < 4 * W) begin
      if (n == 100) begin
        start_req = 1'b1;   // R2: ignored while measuring
        clear_req = 1'b1;   // R7: ignored while measuring
      end else begin
        start_req = 1'b0;
        clear_req = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_req = 1'b0;
    clear_req = 1'b0;
    check(n >= W && n <= 2 * W + 4, "R3 window timing", n, W);
    check(done_a && done_b, "R8 done raised", int'(done_a), 1);
    check_result(p, en);
    if (clear_after) do_clear();
  endtask

  initial begin
    int divs[17] = '{2, 3, 4, 5, 6, 10, 12, 15, 20, 25, 30, 50, 60, 100, 120, 150, 300};
    int r;
    r = $urandom(32'd11);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!done_a && hz_a == '0, "R1 reset done/count", int'(hz_a), 0);
    check(st_a == 7'h3F && su_a == 7'h3F, "R1 reset digits", int'(st_a), 7'h3F);
    // R2 no start: stays idle
    repeat (2 * W + 10) @(negedge clk);
    check(!done_a && !done_b, "R2 no start no result", int'(done_a), 0);
    // R9 fastest input: one-cycle high at period 2; B saturates (150 -> 99)
    run_meas(2, 1'b1, 1'b1);
    // R5 exact boundary 100 in B
    run_meas(3, 1'b1, 1'b1);
    run_meas(4, 1'b1, 1'b1);
    // R4 flat input
    run_meas(10, 1'b0, 1'b1);
    // R7 hold: input and requests change, result frozen
    run_meas(300, 1'b1, 1'b0);
    per_cfg = 2;
    gen_en = 1'b1;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (2 * W) @(negedge clk);
    check(done_a, "R7 done held", int'(done_a), 1);
    check_result(300, 1'b1);
    do_clear();
    // random periods
    for (int i = 0; i < 5; i++) begin
      int p;
      p = divs[$urandom_range(0, 16)];
      run_meas(p, 1'b1, 1'b1);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule